// File: doc/BRIEF.md
# DLFloat Byte-Serial Multiply-Accumulate Unit

This block multiplies pairs of 16-bit DLFloat values and keeps a running sum of the products. A DLFloat word has a sign in bit 15, a 6-bit exponent in bits 14:9 with a bias of 31, and a 9-bit fraction with a hidden leading one in bits 8:0. An exponent of 0 encodes zero, and the block flushes any such word to zero. An exponent of 63 is one combined infinity/NaN code. The pin interface is only 8 bits wide. Each operand word is split across two byte buses in the same cycle. The two operands of a pair arrive in consecutive cycles. The running sum leaves one byte per cycle.

The design is a five-stage pipeline:
- capture operand A
- capture operand B
- register the product
- accumulate
- present the output byte

After reset the stream repeats every two cycles. The accumulator is updated once per completed pair. The result bus presents a byte on every cycle.

Top module: `dlf_mac`

## Requirements
- R1: While reset is low and right after it is released, `res_byte_o` is 0x00 and the accumulator holds +0 (0x0000). The first output bytes after release read 0x00 until the first pair has propagated.
- R2: In every cycle, `lo_byte_i` supplies bits 7:0 and `hi_byte_i` supplies bits 15:8 of an operand word. The first clock edge after reset captures operand A and the next edge captures operand B, alternating from then on.
- R3: The product takes sign = XOR of the operand signs, exponent = sum of exponents minus 31 (plus 1 when the significand product reaches 2), and a truncated fraction. Any operand with exponent 0 gives a product of +0 (0x0000).
- R4: A product whose exponent exceeds 62 saturates to the signed largest normal value (0x7DFF / 0xFDFF). A product whose exponent falls below 1 becomes +0.
- R5: The accumulator adds each product with round-toward-zero, taking bits shifted out during alignment into account. An exact cancellation gives +0 (0x0000).
- R6: An accumulated sum above the largest normal value saturates to 0x7DFF / 0xFDFF. A nonzero sum below the smallest normal value becomes the signed smallest normal value (0x0200 / 0x8200).
- R7: An operand with exponent 63 makes the product 0x7FFF with the product sign. A special value reaching the accumulator stays there: the sum keeps the accumulator's special code and sign.
- R8: The sum including pair k (k counted from 0) appears as its upper byte after clock edge 2k+4 and as its lower byte after edge 2k+5, counting edges from 0 after reset release. The accumulator changes only on edges that complete a pair.
- R9: The result byte alternates every cycle: the upper byte on the edge that captures an A operand, the lower byte on the edge that captures a B operand.
- R10: `hi_oe_o` stays 0x00 at all times, so the high byte bus is only ever an input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lo_byte_i | input | 8 | Operand bits 7:0 |
| hi_byte_i | input | 8 | Operand bits 15:8 (shared bidirectional pins, used as input) |
| res_byte_o | output | 8 | Accumulated result, upper byte then lower byte |
| hi_oe_o | output | 8 | Output enable for the high byte pins, held low |

## Verification
A wrong phase flag shows up at the ports at once: the captured operands and the byte order are both swapped, so every byte after that point is wrong within one or two cycles. A bad product or sum appears four cycles after the B operand of the pair that caused it. Because the accumulator feeds back into itself, an error there corrupts every later result pair rather than just one. The stimulus therefore sets up each saturation, underflow, cancellation and sticky-alignment case directly after a known accumulator value, so that a failure can be traced to a single pair.

// File: rtl/dlf_pkg.sv
`timescale 1ns/1ps
package dlf_pkg;
  parameter int EXP_W  = 6;
  parameter int MAN_W  = 9;
  parameter int BYTE_W = 8;
  parameter int GRS_W  = 3;

  localparam int WORD_W   = 1 + EXP_W + MAN_W;
  localparam int LANES    = WORD_W / BYTE_W;
  localparam int BIAS     = (1 << (EXP_W - 1)) - 1;
  localparam int EXP_TOP  = (1 << EXP_W) - 1;
  localparam int EXP_MAXN = EXP_TOP - 1;
  localparam int MANT_W   = MAN_W + 1;

  typedef struct packed {
    logic              sgn;
    logic [EXP_W-1:0]  exp;
    logic [MAN_W-1:0]  man;
  } dlf_t;

  function automatic dlf_t dlf_zero();
    dlf_t v;
    v.sgn = 1'b0;
    v.exp = '0;
    v.man = '0;
    return v;
  endfunction

  function automatic dlf_t dlf_sat(input logic s);
    dlf_t v;
    v.sgn = s;
    v.exp = EXP_W'(EXP_MAXN);
    v.man = '1;
    return v;
  endfunction

  function automatic dlf_t dlf_nan(input logic s);
    dlf_t v;
    v.sgn = s;
    v.exp = '1;
    v.man = '1;
    return v;
  endfunction

  function automatic dlf_t dlf_min(input logic s);
    dlf_t v;
    v.sgn = s;
    v.exp = EXP_W'(1);
    v.man = '0;
    return v;
  endfunction
endpackage

// File: rtl/dlf_mul.sv
`timescale 1ns/1ps
module dlf_mul
  import dlf_pkg::*;
(
  input  dlf_t a_i,
  input  dlf_t b_i,
  output dlf_t p_o
);
  localparam int PW = 2 * MANT_W;
  localparam int EW = EXP_W + 3;
  localparam logic signed [EW-1:0] E_HI = EW'(EXP_MAXN);
  localparam logic signed [EW-1:0] E_LO = EW'(1);

  logic [PW-1:0]          prod;
  logic signed [EW-1:0]   exp_s;
  logic                   sgn;
  logic                   carry;

  always_comb begin
    sgn   = a_i.sgn ^ b_i.sgn;
    prod  = PW'({1'b1, a_i.man}) * PW'({1'b1, b_i.man});
    carry = prod[PW-1];
    exp_s = EW'(a_i.exp) + EW'(b_i.exp) - EW'(BIAS) + EW'(carry);
    p_o.sgn = sgn;
    p_o.exp = exp_s[EXP_W-1:0];
    p_o.man = carry ? prod[PW-2 -: MAN_W] : prod[PW-3 -: MAN_W];
    if (a_i.exp == EXP_W'(EXP_TOP) || b_i.exp == EXP_W'(EXP_TOP))
      p_o = dlf_nan(sgn);
    else if (a_i.exp == '0 || b_i.exp == '0)
      p_o = dlf_zero();
    else if (exp_s > E_HI)
      p_o = dlf_sat(sgn);
    else if (exp_s < E_LO)
      p_o = dlf_zero();   // flush so tiny products never disturb the sum
  end
endmodule

// File: rtl/dlf_add.sv
`timescale 1ns/1ps
module dlf_add
  import dlf_pkg::*;
(
  input  dlf_t acc_i,
  input  dlf_t inc_i,
  output dlf_t sum_o
);
  localparam int MW  = MANT_W + GRS_W;
  localparam int SW  = MW + 1;
  localparam int LZW = $clog2(SW + 1);
  localparam int EW  = EXP_W + 3;
  localparam logic signed [EW-1:0] E_HI = EW'(EXP_MAXN);
  localparam logic signed [EW-1:0] E_LO = EW'(1);

  dlf_t                  big, sml;
  logic [MW-1:0]         mb, ms, ms_al;
  logic [2*MW-1:0]       sh;
  logic [EXP_W-1:0]      d, dc;
  logic [SW-1:0]         sum, norm;
  logic [LZW-1:0]        lz;
  logic                  found;
  logic                  sub;
  logic signed [EW-1:0]  e_r;

  always_comb begin
    if ({acc_i.exp, acc_i.man} >= {inc_i.exp, inc_i.man}) begin
      big = acc_i;
      sml = inc_i;
    end else begin
      big = inc_i;
      sml = acc_i;
    end
    mb    = {1'b1, big.man, GRS_W'(0)};
    ms    = {1'b1, sml.man, GRS_W'(0)};
    d     = big.exp - sml.exp;
    dc    = (d > EXP_W'(MW)) ? EXP_W'(MW) : d;
    sh    = {ms, MW'(0)} >> dc;
    // bits shifted past the guard positions collapse into one sticky bit
    ms_al = sh[2*MW-1:MW] | MW'(|sh[MW-1:0]);
    sub   = big.sgn ^ sml.sgn;
    sum   = sub ? ({1'b0, mb} - {1'b0, ms_al}) : ({1'b0, mb} + {1'b0, ms_al});

    lz    = '0;
    found = 1'b0;
    for (int i = SW - 1; i >= 0; i--) begin
      if (!found && sum[i]) begin
        lz    = LZW'(SW - 1 - i);
        found = 1'b1;
      end
    end
    norm = sum << lz;
    e_r  = EW'(big.exp) + EW'(1) - EW'(lz);

    sum_o.sgn = big.sgn;
    sum_o.exp = e_r[EXP_W-1:0];
    sum_o.man = norm[SW-2 -: MAN_W];

    if (acc_i.exp == EXP_W'(EXP_TOP))
      sum_o = dlf_nan(acc_i.sgn);
    else if (inc_i.exp == EXP_W'(EXP_TOP))
      sum_o = dlf_nan(inc_i.sgn);
    else if (acc_i.exp == '0)
      sum_o = inc_i;
    else if (inc_i.exp == '0)
      sum_o = acc_i;
    else if (sum == '0)
      sum_o = dlf_zero();
    else if (e_r > E_HI)
      sum_o = dlf_sat(big.sgn);
    else if (e_r < E_LO)
      sum_o = dlf_min(big.sgn);
  end
endmodule

// File: rtl/dlf_byte_io.sv
`timescale 1ns/1ps
module dlf_byte_io
  import dlf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BYTE_W-1:0] lo_byte_i,
  input  logic [BYTE_W-1:0] hi_byte_i,
  input  dlf_t              acc_i,
  output dlf_t              op_a_o,
  output dlf_t              op_b_o,
  output logic              phase_o,
  output logic              pair_v_o,
  output logic [BYTE_W-1:0] res_byte_o
);
  logic [LANES-1:0][BYTE_W-1:0] in_lanes;
  logic [LANES-1:0][BYTE_W-1:0] acc_lanes;
  logic                         phase_q;
  logic                         pair_v_q;
  dlf_t                         op_a_q, op_b_q;
  logic [BYTE_W-1:0]            res_q;

  assign in_lanes[0] = lo_byte_i;
  assign in_lanes[1] = hi_byte_i;
  assign acc_lanes   = acc_i;

  // phase 0: operand A in, upper byte out; phase 1: operand B in, lower byte out
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= 1'b0;
      pair_v_q <= 1'b0;
      op_a_q   <= '0;
      op_b_q   <= '0;
      res_q    <= '0;
    end else begin
      phase_q <= ~phase_q;
      if (!phase_q) begin
        op_a_q <= dlf_t'(in_lanes);
        res_q  <= acc_lanes[LANES-1];
      end else begin
        op_b_q   <= dlf_t'(in_lanes);
        pair_v_q <= 1'b1;
        res_q    <= acc_lanes[0];
      end
    end
  end

  assign op_a_o     = op_a_q;
  assign op_b_o     = op_b_q;
  assign phase_o    = phase_q;
  assign pair_v_o   = pair_v_q;
  assign res_byte_o = res_q;
endmodule

// File: rtl/dlf_mac.sv
`timescale 1ns/1ps
module dlf_mac
  import dlf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BYTE_W-1:0] lo_byte_i,
  input  logic [BYTE_W-1:0] hi_byte_i,
  output logic [BYTE_W-1:0] res_byte_o,
  output logic [BYTE_W-1:0] hi_oe_o
);
  dlf_t op_a_q, op_b_q;
  dlf_t prod_d, prod_q;
  dlf_t sum_d, acc_q;
  logic phase_q;
  logic pair_v_q;
  logic prod_v_q;

  dlf_byte_io u_io (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lo_byte_i  (lo_byte_i),
    .hi_byte_i  (hi_byte_i),
    .acc_i      (acc_q),
    .op_a_o     (op_a_q),
    .op_b_o     (op_b_q),
    .phase_o    (phase_q),
    .pair_v_o   (pair_v_q),
    .res_byte_o (res_byte_o)
  );

  dlf_mul u_mul (
    .a_i (op_a_q),
    .b_i (op_b_q),
    .p_o (prod_d)
  );

  dlf_add u_add (
    .acc_i (acc_q),
    .inc_i (prod_q),
    .sum_o (sum_d)
  );

  // product registered on A edges, accumulated on the following B edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prod_q   <= '0;
      prod_v_q <= 1'b0;
      acc_q    <= '0;
    end else if (!phase_q) begin
      prod_q   <= prod_d;
      prod_v_q <= pair_v_q;
    end else if (prod_v_q) begin
      acc_q <= sum_d;
    end
  end

  assign hi_oe_o = '0;
endmodule

// File: rtl/dlf_mac_chk.sv
`timescale 1ns/1ps
module dlf_mac_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        phase_i,
  input logic [15:0] acc_i,
  input logic [15:0] prod_i,
  input logic [15:0] op_a_i,
  input logic [7:0]  res_byte_i,
  input logic [7:0]  hi_oe_i
);
  p_oe_low_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_oe_i == 8'h00);

  p_phase_flip_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> phase_i != $past(phase_i));

  p_upper_first_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_i |-> res_byte_i == acc_i[15:8]);

  p_acc_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !phase_i |=> $stable(acc_i));

  p_special_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i[14:0] == 15'h7FFF |=> acc_i[14:0] == 15'h7FFF);

  p_zero_prod_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!phase_i && op_a_i[14:9] == 6'd0) |=> prod_i == 16'h0000);
endmodule

bind dlf_mac dlf_mac_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .phase_i    (phase_q),
  .acc_i      (acc_q),
  .prod_i     (prod_q),
  .op_a_i     (op_a_q),
  .res_byte_i (res_byte_o),
  .hi_oe_i    (hi_oe_o)
);

// File: tb/sim_dlf_mac.sv
`timescale 1ns/1ps
module sim_dlf_mac;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] lo_b = 8'h00;
  logic [7:0] hi_b = 8'h00;
  logic [7:0] res;
  logic [7:0] oe;

  int  n_chk = 0;
  int  n_err = 0;
  bit  done  = 1'b0;

  logic [7:0]  exp_q[$];
  string       tag_q[$];
  logic [15:0] acc_m = 16'h0000;

  always #4 clk = ~clk;

  dlf_mac u0 (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .lo_byte_i  (lo_b),
    .hi_byte_i  (hi_b),
    .res_byte_o (res),
    .hi_oe_o    (oe)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  function automatic real pow2(input int e);
    real r = 1.0;
    if (e >= 0) for (int i = 0; i < e; i++) r = r * 2.0;
    else        for (int i = 0; i < -e; i++) r = r / 2.0;
    return r;
  endfunction

  function automatic real to_real(input logic [15:0] v);
    real r;
    if (v[14:9] == 6'd0) return 0.0;
    r = (1.0 + real'(v[8:0]) / 512.0) * pow2(int'(v[14:9]) - 31);
    return v[15] ? -r : r;
  endfunction

  function automatic logic [15:0] encode(input real r, output int be);
    real  a;
    int   e = 0;
    logic s;
    int   f;
    s = (r < 0.0);
    a = s ? -r : r;
    while (a >= 2.0) begin a = a / 2.0; e++; end
    while (a < 1.0)  begin a = a * 2.0; e--; end
    be = e + 31;
    f  = $rtoi((a - 1.0) * 512.0);
    return {s, 6'(be), 9'(f)};
  endfunction

  function automatic logic [15:0] model_mul(input logic [15:0] a, input logic [15:0] b);
    logic s = a[15] ^ b[15];
    int be;
    logic [15:0] v;
    if (a[14:9] == 6'd63 || b[14:9] == 6'd63) return {s, 15'h7FFF};
    if (a[14:9] == 6'd0 || b[14:9] == 6'd0) return 16'h0000;
    v = encode(to_real(a) * to_real(b), be);
    if (be > 62) return {s, 15'h7DFF};
    if (be < 1) return 16'h0000;
    return v;
  endfunction

  function automatic logic [15:0] model_add(input logic [15:0] x, input logic [15:0] y);
    real r;
    int be;
    logic [15:0] v;
    if (x[14:9] == 6'd63) return {x[15], 15'h7FFF};
    if (y[14:9] == 6'd63) return {y[15], 15'h7FFF};
    if (x[14:9] == 6'd0) return y;
    if (y[14:9] == 6'd0) return x;
    r = to_real(x) + to_real(y);
    if (r == 0.0) return 16'h0000;
    v = encode(r, be);
    if (be > 62) return {v[15], 15'h7DFF};
    if (be < 1) return {v[15], 15'h0200};
    return v;
  endfunction

  // drive one word, clock it, then compare the byte the edge produced
  task automatic step(input logic [15:0] w);
    logic [7:0] e;
    string      t;
    lo_b = w[7:0];
    hi_b = w[15:8];
    @(posedge clk);
    @(negedge clk);
    if (exp_q.size() == 0) begin
      check(1'b0, "R8 queue", int'(res), 0);
    end else begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(res === e, {t, " R8 R9"}, int'(res), int'(e));
    end
    check(oe === 8'h00, "R10", int'(oe), 0);
  endtask

  task automatic pair(input logic [15:0] a, input logic [15:0] b, input string tag);
    step(a);
    step(b);
    acc_m = model_add(acc_m, model_mul(a, b));
    exp_q.push_back(acc_m[15:8]);
    tag_q.push_back(tag);
    exp_q.push_back(acc_m[7:0]);
    tag_q.push_back(tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    check(res === 8'h00, "R1 in reset", int'(res), 0);
    @(negedge clk);
    rst_ni = 1'b1;
    check(res === 8'h00, "R1 after release", int'(res), 0);
    check(oe === 8'h00, "R10", int'(oe), 0);
    for (int i = 0; i < 4; i++) begin
      exp_q.push_back(8'h00);
      tag_q.push_back("R1");
    end
    pair(16'h3E00, 16'h3E00, "R2 R3");      // 1.0 * 1.0
    pair(16'h3F00, 16'h4000, "R3 R5");      // 1.5 * 2.0 -> acc 4.0
    pair(16'hBE80, 16'h4000, "R3 R5");      // -2.5 -> acc 1.5
    pair(16'h0000, 16'h5555, "R3");         // zero operand
    pair(16'hBF00, 16'h3E00, "R5");         // exact cancellation
    pair(16'h0400, 16'h2000, "R4");         // product underflow
    pair(16'h7000, 16'h7000, "R4");         // product overflow
    pair(16'h7000, 16'h7000, "R6");         // sum overflow
    pair(16'hF000, 16'h7000, "R5");         // -max cancels +max
    pair(16'h2100, 16'h2000, "R3");         // smallest-exponent product
    pair(16'hA000, 16'h2000, "R6");         // sum underflow to min normal
    pair(16'h3E01, 16'h3E01, "R2 R3 R5");   // truncated product
    pair(16'hAA00, 16'h2A00, "R5");         // sticky on far alignment
    pair(16'h7E00, 16'h3E00, "R7");         // special operand
    pair(16'h3E00, 16'h3E00, "R7");         // special stays
    pair(16'h0000, 16'h0000, "R8");
    pair(16'h0000, 16'h0000, "R8");
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=0x0 expected=0x1");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule